// File: doc/BRIEF.md
# I2C Register-Transaction Sequencer

This block sits between a command source and a byte-level I2C engine. It turns one command into the whole series of control-register writes that the engine needs for a register-addressed transfer or a device probe, so no processor has to drive the engine byte by byte. A command names the operation, a 7-bit device address, a register address of up to 32 bits sent as 0 to 4 bytes, and a byte count. Write data is pulled from a port one byte at a time. Read data is pushed out as single-cycle strobes.

Every step writes the engine's control byte and, for a send, its data byte. The sequencer then polls the engine's completion flag at a fixed interval, up to a parameterised number of samples. When the flag is seen, the engine's status code must match the code expected for that step. A mismatch or an exhausted poll budget ends the transfer early and produces a packed 32-bit diagnostic word. A stop condition is always issued last. Its completion is recognised by the status going to the idle code, because the flag does not rise for a stop. The command finishes with a one-cycle `done` carrying the result, which is zero on success.

The engine uses these control bits: enable 0x40, start 0x20, stop 0x10, flag 0x08, ack 0x04. Writing a control byte with the flag bit clear releases the engine for its next action.

Top module: `i2c_txn_seq`

## Requirements
- R1: `cmd_ready` is high only while idle. A command is taken on `cmd_valid` while ready, and the next cycle writes control 0x60 (start). `cmd_valid` while busy has no effect on the control writes or the result.
- R2: A write (`cmd_op`=0) issues start (expects 0x08), then device byte {chip,0} with control 0x40 (expects 0x18), then the register bytes, then each data byte taken from `wr_data` with one `wr_pop` per byte (expects 0x28 each), then stop.
- R3: Register bytes are sent least significant first: reg[7:0], then reg[15:8], and so on, for `cmd_alen` bytes. Values above 4 are treated as 4, and 0 sends none. Each register byte expects 0x28.
- R4: A read (`cmd_op`=1) sends the device byte and register bytes as a write does. It then issues a second start (control 0x60, expects 0x10) with no stop before it, then {chip,1} (expects 0x40).
- R5: Each read byte is requested with control 0x44 (ack, expects 0x50), except the last, which uses 0x40 (nack, expects 0x58). Each received byte appears on `rd_data` with a one-cycle `rd_valid`, in order.
- R6: A probe (`cmd_op`=2 or 3) issues start, {chip,1} (expects 0x40), one nack receive (expects 0x58, byte delivered on `rd_data`), then stop.
- R7: A read with byte count 0 goes from the {chip,1} step straight to stop.
- R8: If the flag is seen with a status other than expected, no further transfer step is issued. The result is {0x01, control|0x08, status, expected}.
- R9: If the flag is not seen within `POLL_LIMIT` samples taken every `POLL_GAP` cycles, the step times out. The result is {0x02, control, status, expected}. The stop control write follows the timed-out step's write by POLL_GAP*POLL_LIMIT+1 cycles.
- R10: Stop (control 0x50) is the last control write of every command, including after an error. Its wait ends on status 0xF8. If 0xF8 does not appear within the poll budget and no step error happened, the result is {0x02, 0x50, status, 0xF8}. Otherwise the first step error is kept.
- R11: After reset the block is idle with `done` low. `done` is a one-cycle pulse per command, and `result` is zero when every step and the stop succeeded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 write, 1 read, 2 or 3 probe |
| cmd_chip | input | 7 | Device address |
| cmd_reg | input | 32 | Register address |
| cmd_alen | input | 3 | Register address bytes, 0 to 4 |
| cmd_len | input | LEN_W | Data byte count |
| cmd_ready | output | 1 | Idle, command can be taken |
| wr_data | input | 8 | Next byte to write |
| wr_pop | output | 1 | `wr_data` consumed this cycle |
| rd_valid | output | 1 | Received byte strobe |
| rd_data | output | 8 | Received byte |
| eng_ctrl_we | output | 1 | Engine control-byte write |
| eng_ctrl | output | 8 | Engine control byte |
| eng_data_we | output | 1 | Engine data-byte write |
| eng_txd | output | 8 | Engine byte to send |
| eng_iflg | input | 1 | Engine step-complete flag |
| eng_stat | input | 8 | Engine status code |
| eng_rxd | input | 8 | Engine received byte |
| done | output | 1 | Command finished (one cycle) |
| result | output | 32 | Zero or packed error word |

## Verification
The command table covers writes with two, four and zero register bytes, reads of four bytes, one byte and zero bytes, and a probe. Together these separate the register-byte order, the point where the read turns around, and the ack-versus-nack choice for the last byte. An engine model in the bench derives its status codes from what the sequencer writes. It injects a wrong code at chosen steps (the first start, a register byte, the read-direction device byte), a missing flag, and a missing idle status after stop. This shows that the error word fields, early termination and the closing stop come from the failing step. The cycle gap between the hung step and the stop measures the poll budget, and a command presented while busy shows it is dropped.

// File: rtl/i2cseq_pkg.sv
// Shared types and code values for the I2C register-transaction sequencer.
// Assumes an engine whose control bits and status codes match these constants.
package i2cseq_pkg;
    typedef enum logic [1:0] {OP_WRITE = 2'd0, OP_READ = 2'd1, OP_PROBE = 2'd2} op_e;
    typedef enum logic [2:0] {
        PH_START, PH_CHIPW, PH_REG, PH_WDATA, PH_RESTART, PH_CHIPR, PH_RDATA, PH_STOP
    } phase_e;
    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} state_e;

    localparam logic [7:0] CB_ACK   = 8'h04;
    localparam logic [7:0] CB_FLAG  = 8'h08;
    localparam logic [7:0] CB_STOP  = 8'h10;
    localparam logic [7:0] CB_START = 8'h20;
    localparam logic [7:0] CB_EN    = 8'h40;

    localparam logic [7:0] SC_START  = 8'h08;
    localparam logic [7:0] SC_RSTART = 8'h10;
    localparam logic [7:0] SC_AW_ACK = 8'h18;
    localparam logic [7:0] SC_DW_ACK = 8'h28;
    localparam logic [7:0] SC_AR_ACK = 8'h40;
    localparam logic [7:0] SC_DR_ACK = 8'h50;
    localparam logic [7:0] SC_DR_NAK = 8'h58;
    localparam logic [7:0] SC_IDLE   = 8'hF8;

    localparam logic [7:0] EC_WRONG  = 8'h01;
    localparam logic [7:0] EC_TMO    = 8'h02;
endpackage

// File: rtl/i2cseq_step_plan.sv
// Step planner: from the current phase and command fields, produce the
// control byte, the optional byte to send and the status code expected.
// Purely combinational; assumes idx selects the byte within the phase.
module i2cseq_step_plan
    import i2cseq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  phase_e             phase,
    input  logic [6:0]         chip,
    input  logic [31:0]        regaddr,
    input  logic [CNT_W-1:0]   idx,
    input  logic               last_rx,
    input  logic [7:0]         wr_data,
    output logic [7:0]         ctrl,
    output logic [7:0]         tx,
    output logic               tx_en,
    output logic [7:0]         exp_st,
    output logic               wait_idle
);
    // Decode the step that the phase calls for
    always_comb begin
        ctrl      = CB_EN;
        tx        = 8'h00;
        tx_en     = 1'b0;
        exp_st    = SC_IDLE;
        wait_idle = 1'b0;
        unique case (phase)
            PH_START: begin
                ctrl   = CB_EN | CB_START;
                exp_st = SC_START;
            end
            PH_RESTART: begin
                ctrl   = CB_EN | CB_START;
                exp_st = SC_RSTART;
            end
            PH_CHIPW, PH_CHIPR: begin
                tx     = {chip, phase == PH_CHIPR};
                tx_en  = 1'b1;
                exp_st = tx[0] ? SC_AR_ACK : SC_AW_ACK;
            end
            PH_REG: begin
                tx     = regaddr[{idx[1:0], 3'b000} +: 8];
                tx_en  = 1'b1;
                exp_st = SC_DW_ACK;
            end
            PH_WDATA: begin
                tx     = wr_data;
                tx_en  = 1'b1;
                exp_st = SC_DW_ACK;
            end
            PH_RDATA: begin
                ctrl   = last_rx ? CB_EN : (CB_EN | CB_ACK);
                exp_st = last_rx ? SC_DR_NAK : SC_DR_ACK;
            end
            PH_STOP: begin
                ctrl      = CB_EN | CB_STOP;
                wait_idle = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/i2cseq_poll_timer.sv
// Poll timer: after restart, raises tick every GAP cycles while run is high,
// and marks the LIMIT-th tick as final. Assumes GAP >= 1 and LIMIT >= 1.
module i2cseq_poll_timer #(
    parameter int GAP   = 4,
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick,
    output logic final_tick
);
    localparam int GW = (GAP > 1) ? $clog2(GAP) : 1;
    localparam int PW = $clog2(LIMIT + 1);

    logic [GW-1:0] gap_q;
    logic [PW-1:0] polls_q;

    assign tick       = run && (gap_q == '0);
    assign final_tick = tick && (polls_q == PW'(LIMIT - 1));

    // Count cycles between samples and samples taken in this wait
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            gap_q   <= GW'(GAP - 1);
            polls_q <= '0;
        end else if (run) begin
            if (gap_q == '0) begin
                gap_q <= GW'(GAP - 1);
                if (polls_q != PW'(LIMIT - 1)) polls_q <= polls_q + 1'b1;
            end else begin
                gap_q <= gap_q - 1'b1;
            end
        end
    end

    // R9
    poll_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        polls_q < PW'(LIMIT));
endmodule

// File: rtl/i2c_txn_seq.sv
// I2C register-transaction sequencer top. Takes one command while idle,
// drives the engine step by step, checks each status, packs an error word
// on the first failure and always closes with a stop.
// Assumes the engine clears its flag on any control write.
module i2c_txn_seq
    import i2cseq_pkg::*;
#(
    parameter int LEN_W      = 8,
    parameter int POLL_GAP   = 4,
    parameter int POLL_LIMIT = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [6:0]        cmd_chip,
    input  logic [31:0]       cmd_reg,
    input  logic [2:0]        cmd_alen,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              cmd_ready,
    input  logic [7:0]        wr_data,
    output logic              wr_pop,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              eng_ctrl_we,
    output logic [7:0]        eng_ctrl,
    output logic              eng_data_we,
    output logic [7:0]        eng_txd,
    input  logic              eng_iflg,
    input  logic [7:0]        eng_stat,
    input  logic [7:0]        eng_rxd,
    output logic              done,
    output logic [31:0]       result
);
    localparam logic [2:0] ALEN_MAX = 3'd4;

    state_e            state_q;
    phase_e            phase_q, nxt_phase;
    op_e               op_q;
    logic [6:0]        chip_q;
    logic [31:0]       reg_q;
    logic [2:0]        alen_q;
    logic [LEN_W-1:0]  len_q, idx_q, nxt_idx;
    logic [31:0]       result_q;
    logic              err_q;
    logic [7:0]        last_ctrl_q;
    logic              rd_valid_q;
    logic [7:0]        rd_data_q;

    logic [7:0] plan_ctrl, plan_tx, plan_exp;
    logic       plan_tx_en, plan_idle, last_rx;
    logic       tick, final_tick;
    phase_e     after_regs;

    assign last_rx = (op_q == OP_PROBE) || (idx_q == len_q - 1'b1);

    i2cseq_step_plan #(.CNT_W(LEN_W)) u_plan (
        .phase(phase_q), .chip(chip_q), .regaddr(reg_q), .idx(idx_q),
        .last_rx(last_rx), .wr_data(wr_data), .ctrl(plan_ctrl), .tx(plan_tx),
        .tx_en(plan_tx_en), .exp_st(plan_exp), .wait_idle(plan_idle)
    );

    i2cseq_poll_timer #(.GAP(POLL_GAP), .LIMIT(POLL_LIMIT)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(state_q == ST_ISSUE),
        .run(state_q == ST_WAIT), .tick(tick), .final_tick(final_tick)
    );

    // Choose the phase that follows a successful step
    always_comb begin
        after_regs = (op_q == OP_WRITE) ? ((len_q != '0) ? PH_WDATA : PH_STOP) : PH_RESTART;
        nxt_phase  = phase_q;
        unique case (phase_q)
            PH_START:   nxt_phase = (op_q == OP_PROBE) ? PH_CHIPR : PH_CHIPW;
            PH_CHIPW:   nxt_phase = (alen_q != 3'd0) ? PH_REG : after_regs;
            PH_REG:     if (idx_q == LEN_W'(alen_q - 3'd1)) nxt_phase = after_regs;
            PH_WDATA:   if (idx_q == len_q - 1'b1) nxt_phase = PH_STOP;
            PH_RESTART: nxt_phase = PH_CHIPR;
            PH_CHIPR:   nxt_phase = ((op_q == OP_PROBE) || (len_q != '0)) ? PH_RDATA : PH_STOP;
            PH_RDATA:   if (last_rx) nxt_phase = PH_STOP;
            default:    nxt_phase = PH_STOP;
        endcase
        nxt_idx = (nxt_phase != phase_q) ? '0 : idx_q + 1'b1;
    end

    // Drive the engine and the command-side outputs
    assign cmd_ready   = (state_q == ST_IDLE);
    assign eng_ctrl_we = (state_q == ST_ISSUE);
    assign eng_ctrl    = plan_ctrl;
    assign eng_data_we = (state_q == ST_ISSUE) && plan_tx_en;
    assign eng_txd     = plan_tx;
    assign wr_pop      = (state_q == ST_ISSUE) && (phase_q == PH_WDATA);
    assign done        = (state_q == ST_DONE);
    assign result      = result_q;
    assign rd_valid    = rd_valid_q;
    assign rd_data     = rd_data_q;

    // Sequencer state: accept, issue, poll, judge, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            phase_q     <= PH_START;
            op_q        <= OP_WRITE;
            chip_q      <= '0;
            reg_q       <= '0;
            alen_q      <= '0;
            len_q       <= '0;
            idx_q       <= '0;
            result_q    <= '0;
            err_q       <= 1'b0;
            last_ctrl_q <= '0;
            rd_valid_q  <= 1'b0;
            rd_data_q   <= '0;
        end else begin
            rd_valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (cmd_valid) begin
                    op_q     <= cmd_op[1] ? OP_PROBE : op_e'(cmd_op);
                    chip_q   <= cmd_chip;
                    reg_q    <= cmd_reg;
                    alen_q   <= (cmd_alen > ALEN_MAX) ? ALEN_MAX : cmd_alen;
                    len_q    <= cmd_len;
                    phase_q  <= PH_START;
                    idx_q    <= '0;
                    result_q <= '0;
                    err_q    <= 1'b0;
                    state_q  <= ST_ISSUE;
                end
                ST_ISSUE: begin
                    last_ctrl_q <= plan_ctrl;
                    state_q     <= ST_WAIT;
                end
                ST_WAIT: if (tick) begin
                    if (plan_idle) begin
                        if (eng_stat == SC_IDLE) begin
                            state_q <= ST_DONE;
                        end else if (final_tick) begin
                            if (!err_q)
                                result_q <= {EC_TMO, last_ctrl_q | (eng_iflg ? CB_FLAG : 8'h00),
                                             eng_stat, SC_IDLE};
                            state_q <= ST_DONE;
                        end
                    end else if (eng_iflg && eng_stat == plan_exp) begin
                        if (phase_q == PH_RDATA) begin
                            rd_valid_q <= 1'b1;
                            rd_data_q  <= eng_rxd;
                        end
                        phase_q <= nxt_phase;
                        idx_q   <= nxt_idx;
                        state_q <= ST_ISSUE;
                    end else if (eng_iflg || final_tick) begin
                        err_q    <= 1'b1;
                        result_q <= {eng_iflg ? EC_WRONG : EC_TMO,
                                     last_ctrl_q | (eng_iflg ? CB_FLAG : 8'h00),
                                     eng_stat, plan_exp};
                        phase_q  <= PH_STOP;
                        idx_q    <= '0;
                        state_q  <= ST_ISSUE;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R1
    start_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (eng_ctrl_we && eng_ctrl == (CB_EN | CB_START)));
    // R10
    stop_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (last_ctrl_q == (CB_EN | CB_STOP)));
    // R5
    rd_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(eng_stat) == SC_DR_ACK || $past(eng_stat) == SC_DR_NAK));
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && cmd_ready));
    // R2
    send_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pop |-> (eng_data_we && eng_ctrl == CB_EN));
endmodule

// File: tb/i2c_txn_seq_tb.sv
module i2c_txn_seq_tb;
    typedef struct packed {
        logic [1:0]  op;
        logic [6:0]  chip;
        logic [31:0] regv;
        logic [2:0]  alen;
        logic [7:0]  len;
        logic [1:0]  fk;   // 0 none, 1 wrong status, 2 no flag, 3 no idle after stop
        logic [5:0]  fs;   // step index of fault (kinds 1 and 2)
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 7'h50, 32'h12345678, 3'd2, 8'd3, 2'd0, 6'd0},
        '{2'd0, 7'h21, 32'hA1B2C3D4, 3'd4, 8'd1, 2'd0, 6'd0},
        '{2'd0, 7'h05, 32'h00000000, 3'd0, 8'd0, 2'd0, 6'd0},
        '{2'd1, 7'h1A, 32'h0000BEEF, 3'd2, 8'd4, 2'd0, 6'd0},
        '{2'd1, 7'h33, 32'h00000077, 3'd1, 8'd1, 2'd0, 6'd0},
        '{2'd1, 7'h44, 32'h00000000, 3'd0, 8'd0, 2'd0, 6'd0},
        '{2'd2, 7'h3C, 32'h00000000, 3'd0, 8'd0, 2'd0, 6'd0},
        '{2'd0, 7'h22, 32'h00000A0B, 3'd2, 8'd2, 2'd1, 6'd3},
        '{2'd1, 7'h2B, 32'h00000011, 3'd1, 8'd2, 2'd1, 6'd4},
        '{2'd2, 7'h60, 32'h00000000, 3'd0, 8'd0, 2'd2, 6'd1},
        '{2'd0, 7'h11, 32'h00000099, 3'd1, 8'd1, 2'd3, 6'd0},
        '{2'd1, 7'h0F, 32'h00000001, 3'd1, 8'd1, 2'd1, 6'd0}
    };

    function automatic string vec_req(int i);
        case (i)
            0: return "R2 R3";
            1: return "R3";
            2: return "R2";
            3: return "R4 R5";
            4: return "R5";
            5: return "R7";
            6: return "R6";
            7: return "R8";
            8: return "R8";
            9: return "R9";
            10: return "R10";
            default: return "R8 R10";
        endcase
    endfunction

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [6:0] cmd_chip = '0;
    logic [31:0] cmd_reg = '0;
    logic [2:0] cmd_alen = '0;
    logic [7:0] cmd_len = '0;
    logic cmd_ready, wr_pop, rd_valid, eng_ctrl_we, eng_data_we, done;
    logic [7:0] wr_data, rd_data, eng_ctrl, eng_txd;
    logic [31:0] result;
    logic m_iflg = 1'b0;
    logic [7:0] m_stat = 8'hF8, m_rxd = 8'h00;

    i2c_txn_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_chip(cmd_chip), .cmd_reg(cmd_reg), .cmd_alen(cmd_alen), .cmd_len(cmd_len),
        .cmd_ready(cmd_ready), .wr_data(wr_data), .wr_pop(wr_pop), .rd_valid(rd_valid),
        .rd_data(rd_data), .eng_ctrl_we(eng_ctrl_we), .eng_ctrl(eng_ctrl),
        .eng_data_we(eng_data_we), .eng_txd(eng_txd), .eng_iflg(m_iflg),
        .eng_stat(m_stat), .eng_rxd(m_rxd), .done(done), .result(result)
    );

    always #10 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    int nl = 0, nrd = 0, ndone = 0, wr_idx = 0;
    int l_ctrl [0:79];
    int l_tx   [0:79];
    int l_t    [0:79];
    int l_rd   [0:79];
    int e_ctrl [0:79];
    int e_tx   [0:79];
    int e_st   [0:79];
    int n_exp, n_rx;
    logic [31:0] e_res;

    // engine model configuration and state
    int cfg_fk = 0, cfg_fs = 0, m_step = 0, rx_cnt = 0, m_cnt = 0;
    bit in_txn = 0, after_start = 0, m_arm = 0, m_stop = 0;
    logic [7:0] m_resp = 8'h00;

    assign wr_data = 8'h30 + wr_idx[7:0];

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 150000", cyc);
            summary();
            $finish;
        end
    end

    // logging of DUT outputs
    always @(posedge clk) if (rst_n) begin
        if (eng_ctrl_we && nl < 80) begin
            l_ctrl[nl] = eng_ctrl;
            l_tx[nl]   = eng_data_we ? int'(eng_txd) : -1;
            l_t[nl]    = cyc;
            nl++;
        end
        if (rd_valid && nrd < 80) begin l_rd[nrd] = rd_data; nrd++; end
        if (wr_pop) wr_idx++;
        if (done) ndone++;
    end

    // engine model: status follows from what is written, with fault injection
    always @(posedge clk) begin
        if (!rst_n) begin
            m_iflg <= 1'b0; m_stat <= 8'hF8; m_cnt = 0;
        end else if (eng_ctrl_we) begin
            m_iflg <= 1'b0; m_stat <= 8'h00;
            m_stop = 0; m_arm = 1;
            if (eng_ctrl & 8'h20) begin
                m_resp = in_txn ? 8'h10 : 8'h08; in_txn = 1; after_start = 1;
            end else if (eng_ctrl & 8'h10) begin
                m_resp = 8'hF8; m_stop = 1; in_txn = 0;
                if (cfg_fk == 3) m_arm = 0;
            end else if (eng_data_we) begin
                m_resp = after_start ? (eng_txd[0] ? 8'h40 : 8'h18) : 8'h28;
                after_start = 0;
            end else begin
                m_resp = (eng_ctrl & 8'h04) ? 8'h50 : 8'h58;
                m_rxd <= 8'hA0 + rx_cnt[7:0]; rx_cnt++;
            end
            if (!m_stop && m_step == cfg_fs && cfg_fk == 1) m_resp = 8'hAA;
            if (!m_stop && m_step == cfg_fs && cfg_fk == 2) m_arm = 0;
            m_step++;
            m_cnt = 3;
        end else if (m_cnt != 0) begin
            m_cnt--;
            if (m_cnt == 0 && m_arm) begin
                m_stat <= m_resp;
                m_iflg <= !m_stop;
            end
        end
    end

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic add_step(int c, int t, int s, bit rx);
        e_ctrl[n_exp] = c; e_tx[n_exp] = t; e_st[n_exp] = s;
        if (rx) n_rx++;
        n_exp++;
    endtask

    // expected control-write sequence and result, from the requirements
    task automatic build_exp(vec_t v);
        int k;
        n_exp = 0; n_rx = 0;
        add_step(8'h60, -1, 8'h08, 0);
        if (v.op[1]) begin
            add_step(8'h40, {v.chip, 1'b1}, 8'h40, 0);
            add_step(8'h40, -1, 8'h58, 1);
        end else begin
            add_step(8'h40, {v.chip, 1'b0}, 8'h18, 0);
            for (int a = 0; a < v.alen; a++) add_step(8'h40, (v.regv >> (8*a)) & 8'hFF, 8'h28, 0);
            if (v.op == 2'd0) begin
                for (int d = 0; d < v.len; d++) add_step(8'h40, 8'h30 + d, 8'h28, 0);
            end else begin
                add_step(8'h60, -1, 8'h10, 0);
                add_step(8'h40, {v.chip, 1'b1}, 8'h40, 0);
                for (int d = 0; d < v.len; d++)
                    add_step((d == v.len - 1) ? 8'h40 : 8'h44, -1, (d == v.len - 1) ? 8'h58 : 8'h50, 1);
            end
        end
        add_step(8'h50, -1, 8'hF8, 0);
        e_res = 32'h0;
        if (v.fk == 1 || v.fk == 2) begin
            k = v.fs;
            if (v.fk == 1) e_res = {8'h01, 8'(e_ctrl[k] | 8'h08), 8'hAA, 8'(e_st[k])};
            else           e_res = {8'h02, 8'(e_ctrl[k]), 8'h00, 8'(e_st[k])};
            n_rx = 0;
            for (int i = 0; i < k; i++) if (e_ctrl[i] != 8'h60 && e_tx[i] < 0 && e_ctrl[i] != 8'h50) n_rx++;
            e_ctrl[k+1] = 8'h50; e_tx[k+1] = -1;
            n_exp = k + 2;
        end else if (v.fk == 3) begin
            e_res = 32'h02500_0F8;
        end
    endtask

    task automatic run_vec(int vi, bit poke);
        vec_t v;
        int bad;
        v = VECS[vi];
        @(negedge clk);
        cfg_fk = v.fk; cfg_fs = v.fs; m_step = 0; rx_cnt = 0; in_txn = 0; after_start = 0;
        nl = 0; nrd = 0; ndone = 0; wr_idx = 0;
        build_exp(v);
        cmd_op = v.op; cmd_chip = v.chip; cmd_reg = v.regv; cmd_alen = v.alen; cmd_len = v.len;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (poke) begin
            repeat (15) @(negedge clk);
            cmd_op = 2'd2; cmd_chip = 7'h7F; cmd_valid = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        chk(result == e_res, vec_req(vi), $sformatf("vector %0d result", vi), result, e_res);
        chk(nl == n_exp, vec_req(vi), $sformatf("vector %0d control write count", vi), nl, n_exp);
        bad = -1;
        for (int i = 0; i < n_exp && i < nl; i++)
            if (bad < 0 && (l_ctrl[i] != e_ctrl[i] || l_tx[i] != e_tx[i])) bad = i;
        if (bad < 0) chk(1'b1, vec_req(vi), "sequence", 0, 0);
        else chk(1'b0, vec_req(vi), $sformatf("vector %0d step %0d ctrl/byte", vi, bad),
                 {l_ctrl[bad][15:0], l_tx[bad][15:0]}, {e_ctrl[bad][15:0], e_tx[bad][15:0]});
        chk(l_ctrl[nl-1] == 8'h50, "R10", $sformatf("vector %0d last control is stop", vi), l_ctrl[nl-1], 8'h50);
        bad = (nrd == n_rx) ? -1 : 0;
        for (int i = 0; i < nrd && i < n_rx; i++) if (bad < 0 && l_rd[i] != 8'hA0 + i) bad = i;
        chk(bad < 0, (n_rx > 0) ? "R5" : "R2", $sformatf("vector %0d received bytes (count %0d)", vi, nrd),
            nrd, n_rx);
        @(negedge clk);
        chk(ndone == 1 && !done && cmd_ready, "R11", $sformatf("vector %0d done pulse count", vi), ndone, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 and R1: state after reset
        chk(cmd_ready && !done && !eng_ctrl_we && result == 0, "R11", "reset state",
            {cmd_ready, done, eng_ctrl_we}, 3'b100);
        chk(cmd_ready == 1'b1, "R1", "ready after reset", cmd_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            run_vec(i, 1'b0);
            // R9: stop follows the hung step by POLL_GAP*POLL_LIMIT+1 cycles
            if (i == 9) chk(l_t[2] - l_t[1] == 4001, "R9", "timeout window cycles",
                            l_t[2] - l_t[1], 4001);
        end
        // R1: a command offered while busy is ignored
        run_vec(0, 1'b1);
        // R3: address length above 4 behaves as 4
        begin
            vec_t v;
            v = VECS[1];
            @(negedge clk);
            cfg_fk = 0; cfg_fs = 0; m_step = 0; rx_cnt = 0; in_txn = 0; after_start = 0;
            nl = 0; nrd = 0; ndone = 0; wr_idx = 0;
            build_exp(v);
            cmd_op = v.op; cmd_chip = v.chip; cmd_reg = v.regv; cmd_alen = 3'd7; cmd_len = v.len;
            cmd_valid = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
            while (!done) @(negedge clk);
            chk(nl == n_exp && l_tx[5] == 8'hA1, "R3", "length 7 clamps to 4", nl, n_exp);
        end
        summary();
        $finish;
    end
endmodule